// File: doc/BRIEF.md
# Not-Recently-Used Victim Selector

This block holds the replacement state for a set-associative cache that uses a single reference flag per way. A flag of 0 marks a way as recently used, and a flag of 1 marks it as a candidate for eviction. A fill clears the flag of the filled way, and so does a hit. A victim request returns a way whose flag is still 1. If the addressed set has no candidate left, the request first raises every flag in that set and then picks a way.

When several ways qualify, a tie-break rule chosen at elaboration picks one of them:

- **Fixed:** the lowest-numbered candidate.
- **Rotating:** a per-set pointer that moves one past each victim.
- **Random:** a start position taken from a free-running linear feedback shift register.

One set index serves every input in a cycle. A hit, a victim request and a fill can all arrive in the same cycle, and their ordering inside the cycle is fixed. Tags, data and any choice of policy between sets belong to the surrounding cache.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset, every reference flag in every set is 1 and every rotating pointer is at way 0, so the first victim request to any set in fixed or rotating mode returns way 0.
- R2: A fill of way `fill_way` (when `fill_vld` = 1) writes that way's flag in set `set_idx` to 0 at the next clock edge.
- R3: A hit on way `hit_way` (when `hit_vld` = 1) writes that way's flag in set `set_idx` to 0 at the next clock edge.
- R4: `vic_way` is valid combinationally in the same cycle as `vic_req`, and it always names a way whose flag is 1 once any hit in that cycle has been applied.
- R5: When a victim request finds no flag at 1, the flags of every way in that set become 1. The exception is a way hit in that same cycle. The victim is then chosen among the raised flags.
- R6: A fill in the same cycle as a victim request is applied after the bulk raise, so the filled way ends with flag 0.
- R7: A hit and a victim request in the same cycle apply the hit first, so `vic_way` never equals `hit_way`.
- R8: With `TIE_MODE` = 0 (fixed), the victim is the lowest-numbered candidate.
- R9: With `TIE_MODE` = 1 (rotating), the search for a victim starts at the set's pointer and wraps upward. After every victim request the pointer becomes victim + 1 modulo `WAYS`.
- R10: With `TIE_MODE` = 2 (random), the search starts at the low bits of an 8-bit LFSR that steps every cycle, so repeated requests to a set whose flags are all 1 return more than one distinct way.
- R11: State in one set is unaffected by hits, fills and victim requests addressed to another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_idx | input | $clog2(SETS) | Set addressed by every operation this cycle |
| hit_vld | input | 1 | A lookup hit in the addressed set |
| hit_way | input | $clog2(WAYS) | Way that hit |
| vic_req | input | 1 | Request for a victim way in the addressed set |
| fill_vld | input | 1 | A line is installed in the addressed set |
| fill_way | input | $clog2(WAYS) | Way being installed |
| vic_way | output | $clog2(WAYS) | Chosen victim, valid while `vic_req` is 1 |

## Verification
The hardest case to reach is a single cycle that combines an exhausted set, a bulk raise, a hit excluded from the raise and a fill landing on the chosen victim. Reaching it requires first clearing every flag of a set through separate fills or hits, and only then issuing the combined request. The directed tasks do this on dedicated sets. They drive the same stimulus into fixed, rotating and random instances and compare the fixed and rotating victims against a bench model of the flags and pointers. For random mode, the bench checks that each victim is a valid candidate and that the chosen ways vary.

// File: rtl/nru_pkg.sv
// Shared constants for the not-recently-used victim selector.
// Assumes: tie-break codes are fixed here and decoded by the top module.
package nru_pkg;
    localparam logic [1:0] TB_FIXED  = 2'd0;
    localparam logic [1:0] TB_ROTATE = 2'd1;
    localparam logic [1:0] TB_RANDOM = 2'd2;
    localparam int         LFSR_DEF_W = 8;
endpackage

// File: rtl/nru_ref_array.sv
// Reference-flag storage: one flag per way per set, 1 = not recently used.
// Assumes: one read port and one write port on the same set index each cycle.
module nru_ref_array #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int SW = $clog2(SETS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SW-1:0]              idx,
    input  logic                       wr_en,
    input  logic [WAYS-1:0]            wr_bits,
    output logic [WAYS-1:0]            rd_bits,
    output logic [SETS-1:0][WAYS-1:0]  all_bits
);
    logic [SETS-1:0][WAYS-1:0] flags_q;

    // Store updated flags; reset leaves every way as a candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '1;
        end else if (wr_en) begin
            flags_q[idx] <= wr_bits;
        end
    end

    // Expose the addressed set and the full array.
    assign rd_bits  = flags_q[idx];
    assign all_bits = flags_q;
endmodule

// File: rtl/nru_pick.sv
// Circular first-one search: returns the first set bit of cand at or above start.
// Assumes: WAYS is a power of two so index arithmetic wraps naturally; cand nonzero.
module nru_pick #(
    parameter int WAYS = 4,
    localparam int WW = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] cand,
    input  logic [WW-1:0]   start,
    output logic [WW-1:0]   way
);
    // Scan ways in wrapped order from start, keep the first candidate.
    always_comb begin
        logic          found;
        logic [WW-1:0] idx;
        way   = '0;
        found = 1'b0;
        for (int k = 0; k < WAYS; k++) begin
            idx = start + WW'(k);
            if (!found && cand[idx]) begin
                way   = idx;
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nru_lfsr.sv
// Free-running Fibonacci LFSR used as the random tie-break source.
// Assumes: TAPS describes a maximal-length polynomial for W bits; SEED nonzero.
module nru_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    // Step once per cycle; feedback is the parity of the tapped bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else begin
            state <= {state[W-2:0], ^(state & TAPS)};
        end
    end
endmodule

// File: rtl/nru_victim_sel.sv
// Not-recently-used victim selector for a set-associative cache.
// Per cycle on set_idx: hit clears its flag, then a victim request with no
// candidate raises all flags (except the hit way), then a victim is picked
// by the TIE_MODE rule, then a fill clears its flag. Assumes WAYS is a power
// of two, WAYS >= 2, and LFSR_W >= log2(WAYS).
module nru_victim_sel #(
    parameter int         SETS     = 16,
    parameter int         WAYS     = 4,
    parameter logic [1:0] TIE_MODE = nru_pkg::TB_ROTATE,
    parameter int         LFSR_W   = nru_pkg::LFSR_DEF_W,
    localparam int        SW       = $clog2(SETS),
    localparam int        WW       = $clog2(WAYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] set_idx,
    input  logic          hit_vld,
    input  logic [WW-1:0] hit_way,
    input  logic          vic_req,
    input  logic          fill_vld,
    input  logic [WW-1:0] fill_way,
    output logic [WW-1:0] vic_way
);
    logic [WAYS-1:0]           cur_bits;
    logic [WAYS-1:0]           hit_mask;
    logic [WAYS-1:0]           fill_mask;
    logic [WAYS-1:0]           post_hit;
    logic                      exhausted;
    logic [WAYS-1:0]           cand_bits;
    logic [WAYS-1:0]           next_bits;
    logic                      upd_en;
    logic [WW-1:0]             search_start;
    logic [SETS-1:0][WAYS-1:0] ref_bits;

    nru_ref_array #(.SETS(SETS), .WAYS(WAYS)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (set_idx),
        .wr_en    (upd_en),
        .wr_bits  (next_bits),
        .rd_bits  (cur_bits),
        .all_bits (ref_bits)
    );

    // Ordered flag update: hit, bulk raise, fill.
    always_comb begin
        hit_mask  = hit_vld  ? (WAYS'(1) << hit_way)  : '0;
        fill_mask = fill_vld ? (WAYS'(1) << fill_way) : '0;
        post_hit  = cur_bits & ~hit_mask;
        exhausted = vic_req && (post_hit == '0);
        cand_bits = exhausted ? ~hit_mask : post_hit;
        next_bits = cand_bits & ~fill_mask;
        upd_en    = hit_vld | vic_req | fill_vld;
    end

    // Tie-break start position, chosen by TIE_MODE.
    generate
        if (TIE_MODE == nru_pkg::TB_ROTATE) begin : g_rotate
            logic [SETS-1:0][WW-1:0] ptr_q;
            // Advance the set's pointer one past each victim.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ptr_q <= '0;
                end else if (vic_req) begin
                    ptr_q[set_idx] <= vic_way + WW'(1);
                end
            end
            assign search_start = ptr_q[set_idx];
        end else if (TIE_MODE == nru_pkg::TB_RANDOM) begin : g_random
            logic [LFSR_W-1:0] rnd;
            nru_lfsr #(.W(LFSR_W)) u_lfsr (
                .clk   (clk),
                .rst_n (rst_n),
                .state (rnd)
            );
            assign search_start = rnd[WW-1:0];
        end else begin : g_fixed
            assign search_start = '0;
        end
    endgenerate

    nru_pick #(.WAYS(WAYS)) u_pick (
        .cand  (cand_bits),
        .start (search_start),
        .way   (vic_way)
    );
endmodule

// File: rtl/nru_victim_sel_chk.sv
// Assertion checker for nru_victim_sel, attached by bind below.
// Assumes: reads the candidate vector and flag array driven inside the top.
module nru_victim_sel_chk #(
    parameter int  SETS = 16,
    parameter int  WAYS = 4,
    localparam int SW   = $clog2(SETS),
    localparam int WW   = $clog2(WAYS)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [SW-1:0]             set_idx,
    input logic                      hit_vld,
    input logic [WW-1:0]             hit_way,
    input logic                      vic_req,
    input logic                      fill_vld,
    input logic [WW-1:0]             fill_way,
    input logic [WW-1:0]             vic_way,
    input logic [WAYS-1:0]           cand_bits,
    input logic [SETS-1:0][WAYS-1:0] ref_bits
);
    // R1
    reset_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (&ref_bits));

    // R2
    fill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |=> (ref_bits[$past(set_idx)][$past(fill_way)] == 1'b0));

    // R3
    hit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |=> (ref_bits[$past(set_idx)][$past(hit_way)] == 1'b0));

    // R4
    victim_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vic_req |-> cand_bits[vic_way]);

    // R7
    hit_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_req && hit_vld) |-> (vic_way != hit_way));
endmodule

bind nru_victim_sel nru_victim_sel_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_idx   (set_idx),
    .hit_vld   (hit_vld),
    .hit_way   (hit_way),
    .vic_req   (vic_req),
    .fill_vld  (fill_vld),
    .fill_way  (fill_way),
    .vic_way   (vic_way),
    .cand_bits (cand_bits),
    .ref_bits  (ref_bits)
);

// File: tb/tb_nru_victim_sel.sv
`timescale 1ns/1ps
// Directed bench: the same stimulus drives rotating, fixed and random instances.
module tb_nru_victim_sel;
    localparam int SETS = 8;
    localparam int WAYS = 4;
    localparam int SW   = $clog2(SETS);
    localparam int WW   = $clog2(WAYS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] set_idx = '0;
    logic          hit_vld = 1'b0;
    logic [WW-1:0] hit_way = '0;
    logic          vic_req = 1'b0;
    logic          fill_vld = 1'b0;
    logic [WW-1:0] fill_way = '0;
    logic [WW-1:0] vic_rot, vic_fix, vic_rnd;

    int n_chk = 0;
    int n_bad = 0;

    // Model state from the requirements.
    logic [WAYS-1:0] mbits [SETS];
    int              mptr  [SETS];

    always #4 clk = ~clk;   // 125 MHz

    nru_victim_sel #(.SETS(SETS), .WAYS(WAYS), .TIE_MODE(2'd1)) dut (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_vld(hit_vld),
        .hit_way(hit_way), .vic_req(vic_req), .fill_vld(fill_vld),
        .fill_way(fill_way), .vic_way(vic_rot));
    nru_victim_sel #(.SETS(SETS), .WAYS(WAYS), .TIE_MODE(2'd0)) dut_fix (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_vld(hit_vld),
        .hit_way(hit_way), .vic_req(vic_req), .fill_vld(fill_vld),
        .fill_way(fill_way), .vic_way(vic_fix));
    nru_victim_sel #(.SETS(SETS), .WAYS(WAYS), .TIE_MODE(2'd2)) dut_rnd (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_vld(hit_vld),
        .hit_way(hit_way), .vic_req(vic_req), .fill_vld(fill_vld),
        .fill_way(fill_way), .vic_way(vic_rnd));

    function automatic int first_from(logic [WAYS-1:0] c, int s);
        for (int k = 0; k < WAYS; k++) begin
            if (c[(s + k) % WAYS]) return (s + k) % WAYS;
        end
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: drive, compare victims against model, update model.
    task automatic step(string req, int s, bit h, int hw, bit v, bit f, int fw,
                        output int rnd_way);
        logic [WAYS-1:0] hm, fm, ph, cand;
        int e_rot;
        @(negedge clk);
        set_idx = SW'(s); hit_vld = h; hit_way = WW'(hw);
        vic_req = v; fill_vld = f; fill_way = WW'(fw);
        hm = h ? (WAYS'(1) << hw) : '0;
        fm = f ? (WAYS'(1) << fw) : '0;
        ph = mbits[s] & ~hm;
        cand = (v && ph == '0) ? ~hm : ph;
        rnd_way = 0;
        #2;
        if (v) begin
            e_rot = first_from(cand, mptr[s]);
            check({req, " rotating"}, int'(vic_rot), e_rot);
            check({req, " fixed"}, int'(vic_fix), first_from(cand, 0));
            check({req, " random-candidate"}, int'(cand[vic_rnd]), 1);
            rnd_way = int'(vic_rnd);
            mptr[s] = (e_rot + 1) % WAYS;
        end
        mbits[s] = cand & ~fm;
        @(posedge clk);
        #1;
        hit_vld = 1'b0; vic_req = 1'b0; fill_vld = 1'b0;
    endtask

    task automatic fill_all(int s);
        int r;
        for (int w = 0; w < WAYS; w++) step("R2", s, 0, 0, 0, 1, w, r);
    endtask

    task automatic test_reset();
        int r;
        step("R1", 0, 0, 0, 1, 0, 0, r);
    endtask

    task automatic test_fill_hit();
        int r;
        step("R2", 1, 0, 0, 0, 1, 0, r);
        step("R3", 1, 1, 1, 0, 0, 0, r);
        step("R8", 1, 0, 0, 1, 0, 0, r);   // expect way 2 in both
    endtask

    task automatic test_all_used();
        int r;
        fill_all(2);
        step("R5", 2, 0, 0, 1, 0, 0, r);   // bulk raise, way 0
        step("R5", 2, 0, 0, 1, 0, 0, r);   // flags still raised
    endtask

    task automatic test_fill_same();
        int r;
        fill_all(3);
        step("R6", 3, 0, 0, 1, 1, 0, r);   // victim 0 refilled at once
        step("R6", 3, 0, 0, 1, 0, 0, r);   // way 0 no longer a candidate
    endtask

    task automatic test_hit_vic();
        int r;
        step("R7", 4, 1, 0, 1, 0, 0, r);
        for (int w = 1; w < WAYS; w++) step("R7", 4, 0, 0, 0, 1, w, r);
        step("R7", 4, 1, 0, 1, 0, 0, r);   // exhausted set, hit way excluded
        step("R7", 4, 0, 0, 1, 0, 0, r);
    endtask

    task automatic test_rotation();
        int r;
        for (int i = 0; i < 6; i++) step("R9", 5, 0, 0, 1, 0, 0, r);
    endtask

    task automatic test_sets();
        int r;
        fill_all(6);
        step("R11", 7, 0, 0, 1, 0, 0, r);  // set 7 untouched by set 6
        step("R11", 6, 0, 0, 1, 0, 0, r);
    endtask

    task automatic test_random();
        int r;
        logic [WAYS-1:0] seen = '0;
        for (int i = 0; i < 24; i++) begin
            step("R10", 7, 0, 0, 1, 0, 0, r);
            seen[r] = 1'b1;
        end
        check("R10 distinct ways", ($countones(seen) >= 2) ? 1 : 0, 1);
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) begin
            mbits[s] = '1;
            mptr[s]  = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 idle victim", int'(vic_fix), 0);
        test_reset();
        test_fill_hit();
        test_all_used();
        test_fill_same();
        test_hit_vic();
        test_rotation();
        test_sets();
        test_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule